// File: doc/BRIEF.md
# Transaction Buffer Slot Tracker

This block keeps the books on the physical slots of a cache controller's transaction buffer. The controller uses it to decide whether a new request can be accepted now, retried later, or granted a credit. It holds a fixed number of slots and a small entry counter for each one. Several logical entries can share one slot, such as a request and the eviction it caused. Slots can also be reserved before they are used, so that a credit handed out earlier is honoured later. The block stores no transaction data and performs no address lookup.

Each operation is one request cycle with `op_valid` high, an operation code and, where needed, a slot index. The block answers exactly one cycle later with `rsp_valid`, an error bit and, for an allocation, the chosen slot. The status outputs are always live:

- the number of occupied slots;
- the fixed capacity;
- the reserved count;
- the available count;
- the answer to an "are at least N slots free" query.

Top module: `slot_tracker`

## Requirements
- R1: After reset, every slot's entry count is zero, `size_o` and `reserved_o` are 0, and `avail_o` and `capacity_o` both equal NUM_SLOTS.
- R2: Allocation (op code 0) takes the lowest-index slot whose entry count is zero and sets that count to 1. The response reports that index in `rsp_slot` with `rsp_err` low.
- R3: Allocation or reservation when `avail_o` is 0 sets `rsp_err`, and no count changes.
- R4: Attach (op code 1) to an occupied slot raises that slot's entry count by one and leaves `size_o` unchanged.
- R5: Attach to a free slot, or to a slot whose count is already at its maximum of 2^CNT_W-1, sets `rsp_err` and changes nothing.
- R6: Detach (op code 2) lowers the named slot's entry count by one. The slot becomes free, and `size_o` drops, only when its count reaches zero.
- R7: Detach from a free slot sets `rsp_err` and changes nothing.
- R8: Reserve (op code 3) raises `reserved_o` by one.
- R9: Unreserve (op code 4) lowers `reserved_o` by one. With `reserved_o` at 0 it sets `rsp_err` and changes nothing.
- R10: `avail_o` always equals `capacity_o - size_o - reserved_o`. `query_ok` is high exactly when `avail_o >= query_n`.
- R11: Every cycle with `op_valid` high yields `rsp_valid` high on the following cycle. Op codes 5 to 7 are answered with `rsp_err` and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 3 | 0 alloc, 1 attach, 2 detach, 3 reserve, 4 unreserve |
| op_slot | input | IDX_W | Slot index for attach and detach |
| query_n | input | NW | Slot count for the availability query |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request was refused; state unchanged |
| rsp_slot | output | IDX_W | Slot chosen by a successful allocation |
| size_o | output | NW | Slots holding at least one entry |
| capacity_o | output | NW | Total slot count |
| reserved_o | output | NW | Reserved slot count |
| avail_o | output | NW | Slots free and not reserved |
| query_ok | output | 1 | At least `query_n` slots available |

## Verification
The bench builds the tracker with NUM_SLOTS=4 and CNT_W=2. With only four slots, a few allocations and one reservation fill the tracker, so the refused allocation and the refused reservation are both easy to reach. A two-bit entry counter saturates after three entries in one slot, which brings the attach-overflow refusal within reach. It also gives a multi-step detach, where the slot stays occupied until its last entry leaves.

// File: rtl/slot_tracker.sv
module slot_tracker #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W     = 2,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int NW       = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [IDX_W-1:0] op_slot,
  input  logic [NW-1:0]    query_n,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [IDX_W-1:0] rsp_slot,
  output logic [NW-1:0]    size_o,
  output logic [NW-1:0]    capacity_o,
  output logic [NW-1:0]    reserved_o,
  output logic [NW-1:0]    avail_o,
  output logic             query_ok
);
  localparam logic [2:0] OP_ALLOC  = 3'd0;
  localparam logic [2:0] OP_ATTACH = 3'd1;
  localparam logic [2:0] OP_DETACH = 3'd2;
  localparam logic [2:0] OP_RESV   = 3'd3;
  localparam logic [2:0] OP_UNRESV = 3'd4;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] busy;
  logic [NW-1:0] resv_q, size_c;
  logic [IDX_W-1:0] free_idx;
  logic [CNT_W-1:0] sel_cnt;
  logic slot_ok, err_c;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_busy
    assign busy[i] = |cnt_q[i];
  end

  always_comb begin
    size_c   = '0;
    free_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      size_c = size_c + NW'(busy[i]);
      if (!busy[i]) free_idx = IDX_W'(i);
    end
  end

  assign slot_ok    = {1'b0, op_slot} < (IDX_W+1)'(NUM_SLOTS);
  assign sel_cnt    = slot_ok ? cnt_q[op_slot] : '0;
  assign size_o     = size_c;
  assign capacity_o = NW'(NUM_SLOTS);
  assign reserved_o = resv_q;
  assign avail_o    = capacity_o - size_c - resv_q;
  assign query_ok   = avail_o >= query_n;

  always_comb begin
    unique case (op_code)
      OP_ALLOC:  err_c = (avail_o == '0);
      OP_ATTACH: err_c = (sel_cnt == '0) || (sel_cnt == CNT_MAX);
      OP_DETACH: err_c = (sel_cnt == '0);
      OP_RESV:   err_c = (avail_o == '0);
      OP_UNRESV: err_c = (resv_q == '0);
      default:   err_c = 1'b1;
    endcase
  end

  wire do_op = op_valid && !err_c;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[i] <= '0;
      else if (do_op) begin
        if (op_code == OP_ALLOC && free_idx == IDX_W'(i))
          cnt_q[i] <= CNT_W'(1);
        else if (op_code == OP_ATTACH && op_slot == IDX_W'(i))
          cnt_q[i] <= cnt_q[i] + CNT_W'(1);
        else if (op_code == OP_DETACH && op_slot == IDX_W'(i))
          cnt_q[i] <= cnt_q[i] - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_slot  <= '0;
    end else begin
      rsp_valid <= op_valid;
      rsp_err   <= op_valid && err_c;
      rsp_slot  <= (op_code == OP_ALLOC) ? free_idx : op_slot;
      if (do_op && op_code == OP_RESV)   resv_q <= resv_q + NW'(1);
      if (do_op && op_code == OP_UNRESV) resv_q <= resv_q - NW'(1);
    end
  end
endmodule

module slot_tracker_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W = 3,
  parameter int NW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [2:0]       op_code,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [NW-1:0]    size_o,
  input logic [NW-1:0]    capacity_o,
  input logic [NW-1:0]    reserved_o,
  input logic [NW-1:0]    avail_o
);
  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> rsp_valid);
  assert_no_overcommit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, size_o} + {1'b0, reserved_o}) <= {1'b0, capacity_o});
  assert_err_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (size_o == $past(size_o) && reserved_o == $past(reserved_o)));
  assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && $past(op_code) == 3'd0) |-> size_o == $past(size_o) + 1'b1);
  assert_alloc_needs_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0 && avail_o == '0) |=> rsp_err);
  assert_resv_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && $past(op_code) == 3'd3) |-> reserved_o == $past(reserved_o) + 1'b1);
  assert_unresv_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && $past(op_code) == 3'd4) |-> reserved_o == $past(reserved_o) - 1'b1);
endmodule

bind slot_tracker slot_tracker_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .size_o(size_o),
  .capacity_o(capacity_o), .reserved_o(reserved_o), .avail_o(avail_o)
);

// File: tb/slot_tracker_bench.sv
module slot_tracker_bench;
  localparam int N = 4;
  localparam int CW = 2;
  localparam int IW = 2;
  localparam int NW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [IW-1:0] op_slot = '0;
  logic [NW-1:0] query_n = '0;
  logic rsp_valid, rsp_err, query_ok;
  logic [IW-1:0] rsp_slot;
  logic [NW-1:0] size_o, capacity_o, reserved_o, avail_o;

  always #2 clk = ~clk;

  slot_tracker #(.NUM_SLOTS(N), .CNT_W(CW)) u_slot_tracker (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_slot(op_slot), .query_n(query_n), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_slot(rsp_slot), .size_o(size_o),
    .capacity_o(capacity_o), .reserved_o(reserved_o), .avail_o(avail_o),
    .query_ok(query_ok));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int mcnt[N];
  int mres = 0;
  int q_err[$], q_slot[$], q_cmp[$];
  string q_req[$];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int occ();
    int s = 0;
    for (int i = 0; i < N; i++) if (mcnt[i] != 0) s++;
    return s;
  endfunction

  task automatic check_status(string req);
    check(size_o == NW'(occ()), {req, " size"}, size_o, occ());
    check(reserved_o == NW'(mres), {req, " reserved"}, reserved_o, mres);
    check(avail_o == NW'(N - occ() - mres), {req, " avail"}, avail_o, N - occ() - mres);
  endtask

  task automatic do_op(int code, int slot, string req);
    int e = 0, s = 0, c = 0, av;
    av = N - occ() - mres;
    case (code)
      0: if (av == 0) e = 1;
         else begin
           c = 1;
           for (int i = N - 1; i >= 0; i--) if (mcnt[i] == 0) s = i;
           mcnt[s] = 1;
         end
      1: if (mcnt[slot] == 0 || mcnt[slot] == 3) e = 1; else mcnt[slot]++;
      2: if (mcnt[slot] == 0) e = 1; else mcnt[slot]--;
      3: if (av == 0) e = 1; else mres++;
      4: if (mres == 0) e = 1; else mres--;
      default: e = 1;
    endcase
    q_err.push_back(e); q_slot.push_back(s); q_cmp.push_back(c); q_req.push_back(req);
    op_valid = 1'b1; op_code = 3'(code); op_slot = IW'(slot);
    @(negedge clk);
    op_valid = 1'b0;
    check_status(req);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_err.size() == 0) check(1'b0, "R11 unexpected rsp", 1, 0);
      else begin
        int e, s, c;
        string r;
        e = q_err.pop_front(); s = q_slot.pop_front();
        c = q_cmp.pop_front(); r = q_req.pop_front();
        check(rsp_err == e[0], {r, " err"}, rsp_err, e);
        if (c != 0) check(rsp_slot == IW'(s), {r, " slot"}, rsp_slot, s);
      end
    end
  end

  task automatic query(int n, string req);
    bit exp_ok;
    query_n = NW'(n);
    #1;
    exp_ok = (N - occ() - mres) >= n;
    check(query_ok == exp_ok, req, query_ok, exp_ok);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(capacity_o == NW'(N), "R1 capacity", capacity_o, N);
    check_status("R1");
    query(4, "R10 query full");
    do_op(0, 0, "R2 alloc a");
    do_op(0, 0, "R2 alloc b");
    do_op(0, 0, "R2 alloc c");
    do_op(1, 1, "R4 attach 1");
    do_op(1, 1, "R4 attach 2");
    do_op(1, 1, "R5 attach overflow");
    do_op(1, 3, "R5 attach free");
    do_op(2, 0, "R6 detach last");
    do_op(0, 0, "R2 refill lowest");
    query(1, "R10 query one");
    do_op(3, 0, "R8 reserve");
    query(1, "R10 query none");
    do_op(0, 0, "R3 alloc full");
    do_op(3, 0, "R3 reserve full");
    do_op(4, 0, "R9 unreserve");
    do_op(4, 0, "R9 unreserve empty");
    do_op(6, 0, "R11 bad op");
    do_op(2, 3, "R7 detach free");
    do_op(2, 1, "R6 detach shared 1");
    do_op(2, 1, "R6 detach shared 2");
    do_op(2, 1, "R6 detach shared 3");
    do_op(0, 0, "R2 alloc after free");
    query(2, "R10 query two");
    repeat (2) @(negedge clk);
    check(q_err.size() == 0, "R11 pending rsp", q_err.size(), 0);
    finish_run();
  end
endmodule